// File: doc/BRIEF.md
# Key-Sequenced Write Guard for Power Configuration Registers

This block stands between a register access port and a bank of power-configuration registers whose contents must not change by accident: the registers that select which events start a power transition, and the pointers to the start of each power sequence. Writes into the protected address windows reach the bank only while the guard is open. Opening it takes two distinct key bytes, written in order to one dedicated key address. Writing zero there, or any other unexpected value, closes it again. Software is expected to close the guard after every configuration change, including after an access that failed.

Requests arrive on a valid/ready port. `req_ready` is low while reset is asserted and rises at the first clock edge after reset is released. From then on it stays high, so a request is accepted in every cycle where `req_valid` is high. Read responses come back one cycle after acceptance on `rsp_valid`/`rsp_data`. This side has no back-pressure, so the consumer must take every response in the cycle it appears. The write strobe toward the bank (`bank_we`) is combinational in the accepting cycle, with address and data passed through unchanged. The key address reads back the guard state.

Top module: `key_guard`

## Requirements
- R1: While `rst_n` is low, `req_ready` and `rsp_valid` are 0. `req_ready` is 1 from the first rising edge after `rst_n` goes high. Reset leaves the guard closed.
- R2: Writing 0xA5 and then 0x5A to the key address 0x2E, in two consecutive accepted writes, opens the guard. The open state is in effect for requests accepted after the second write.
- R3: Writing 0x00 to the key address closes the guard from any state.
- R4: After the first key has been accepted, the next accepted write closes the guard unless it is 0x5A to address 0x2E. This includes writes to any other address, and writing 0xA5 a second time.
- R5: A write to a guarded address (0x20 to 0x27, or 0x30 to 0x3F, bounds included) raises `bank_we` in its accepting cycle only when the guard is open. Otherwise it is dropped with `bank_we` held at 0.
- R6: A write to an address that is neither guarded nor the key address raises `bank_we` in its accepting cycle in every guard state. That write leaves an open guard open.
- R7: While the guard is open, any write to the key address closes it, even a write of either key value.
- R8: A read of address 0x2E returns, one cycle after acceptance, `rsp_data` with bit 0 = 1 if the guard is open and 0 otherwise, and every other bit 0. Reads never change the guard state.
- R9: A read of any other address returns, one cycle after acceptance, the `bank_rdata` value present in the accepting cycle. Reads never raise `bank_we`.
- R10: Writing 0x5A to the key address while the guard is closed and not armed leaves it closed.
- R11: Writes to the key address never raise `bank_we`. `bank_addr` and `bank_wdata` equal `req_addr` and `req_wdata` whenever `bank_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (high after reset) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| bank_we | output | 1 | Gated write strobe to the register bank |
| bank_addr | output | 8 | Address toward the bank |
| bank_wdata | output | 8 | Write data toward the bank |
| bank_rdata | input | 8 | Read data from the bank for the current address |
| rsp_valid | output | 1 | Read response valid, one cycle after a read is accepted |
| rsp_data | output | 8 | Read response data |

## Verification
The hardest situation to reach is the armed state, which lasts for exactly one accepted write and is visible at the ports only through its aftermath. The stimulus arms the guard and then follows at once with each kind of intruder: a write to a free address, a repeat of the first key, a foreign byte, and a zero. A read of the key address and a write to a guarded address then show whether the guard fell back to closed. A behavioural model in the bench predicts `bank_we` and every read response on every clock, so a stale or skipped transition shows up in the very next cycle.

// File: rtl/guard_pkg.sv
package guard_pkg;

  // Guard sequencer states
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  // Address classes seen by the guard
  typedef enum logic [1:0] {
    AC_FREE  = 2'd0,
    AC_KEY   = 2'd1,
    AC_GUARD = 2'd2
  } addr_class_e;

endpackage

// File: rtl/guard_addr_dec.sv
module guard_addr_dec #(
  parameter int                    AW       = 8,
  parameter logic [AW-1:0]         KEY_ADDR = 8'h2E,
  parameter int                    NUM_WIN  = 2,
  parameter logic [NUM_WIN*AW-1:0] WIN_LO   = {8'h30, 8'h20},
  parameter logic [NUM_WIN*AW-1:0] WIN_HI   = {8'h3F, 8'h27}
) (
  input  logic [AW-1:0]            addr,
  output guard_pkg::addr_class_e   cls
);
  import guard_pkg::*;

  logic [NUM_WIN-1:0] hit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [AW-1:0] LO = WIN_LO[w*AW +: AW];
    localparam logic [AW-1:0] HI = WIN_HI[w*AW +: AW];
    assign hit[w] = (addr >= LO) && (addr <= HI);
  end

  always_comb begin
    if (addr == KEY_ADDR)  cls = AC_KEY;
    else if (|hit)         cls = AC_GUARD;
    else                   cls = AC_FREE;
  end

endmodule

// File: rtl/guard_key_seq.sv
module guard_key_seq #(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] KEY_FIRST = 8'hA5,
  parameter logic [DW-1:0] KEY_SECOND = 8'h5A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire,
  input  logic                  wr_is_key,
  input  logic [DW-1:0]         wr_data,
  output guard_pkg::key_state_e state
);
  import guard_pkg::*;

  key_state_e nxt;

  always_comb begin
    nxt = state;
    if (wr_fire) begin
      unique case (state)
        KS_LOCKED: if (wr_is_key && wr_data == KEY_FIRST) nxt = KS_ARMED;
        KS_ARMED:  nxt = (wr_is_key && wr_data == KEY_SECOND) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   if (wr_is_key) nxt = KS_LOCKED;
        default:   nxt = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= KS_LOCKED;
    else        state <= nxt;
  end

endmodule

// File: rtl/guard_rsp.sv
module guard_rsp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic [DW-1:0] rd_value,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_data <= rd_value;
    end
  end

endmodule

// File: rtl/key_guard.sv
module key_guard #(
  parameter int                    AW         = 8,
  parameter int                    DW         = 8,
  parameter logic [AW-1:0]         KEY_ADDR   = 8'h2E,
  parameter logic [DW-1:0]         KEY_FIRST  = 8'hA5,
  parameter logic [DW-1:0]         KEY_SECOND = 8'h5A,
  parameter int                    NUM_WIN    = 2,
  parameter logic [NUM_WIN*AW-1:0] WIN_LO     = {8'h30, 8'h20},
  parameter logic [NUM_WIN*AW-1:0] WIN_HI     = {8'h3F, 8'h27}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          bank_we,
  output logic [AW-1:0] bank_addr,
  output logic [DW-1:0] bank_wdata,
  input  logic [DW-1:0] bank_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  import guard_pkg::*;

  logic        ready_q;
  logic        fire, wr_fire, rd_fire;
  addr_class_e cls;
  key_state_e  key_state;
  logic [DW-1:0] rd_value;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign req_ready = ready_q;
  assign fire      = req_valid && ready_q;
  assign wr_fire   = fire && req_write;
  assign rd_fire   = fire && !req_write;

  guard_addr_dec #(
    .AW(AW), .KEY_ADDR(KEY_ADDR), .NUM_WIN(NUM_WIN), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_dec (
    .addr (req_addr),
    .cls  (cls)
  );

  guard_key_seq #(
    .DW(DW), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .wr_is_key (cls == AC_KEY),
    .wr_data   (req_wdata),
    .state     (key_state)
  );

  // Gate toward the bank: free addresses always, guarded ones only when open
  assign bank_we    = wr_fire && ((cls == AC_FREE) ||
                                  (cls == AC_GUARD && key_state == KS_OPEN));
  assign bank_addr  = req_addr;
  assign bank_wdata = req_wdata;

  // Key address reads back the guard status in bit 0
  assign rd_value = (cls == AC_KEY) ? DW'(key_state == KS_OPEN) : bank_rdata;

  guard_rsp #(.DW(DW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_fire),
    .rd_value  (rd_value),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/key_guard_chk.sv
module key_guard_chk #(
  parameter int                    AW         = 8,
  parameter int                    DW         = 8,
  parameter logic [AW-1:0]         KEY_ADDR   = 8'h2E,
  parameter logic [DW-1:0]         KEY_FIRST  = 8'hA5,
  parameter logic [DW-1:0]         KEY_SECOND = 8'h5A,
  parameter int                    NUM_WIN    = 2,
  parameter logic [NUM_WIN*AW-1:0] WIN_LO     = {8'h30, 8'h20},
  parameter logic [NUM_WIN*AW-1:0] WIN_HI     = {8'h3F, 8'h27}
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  req_write,
  input logic [AW-1:0]         req_addr,
  input logic [DW-1:0]         req_wdata,
  input logic                  bank_we,
  input logic                  rsp_valid,
  input guard_pkg::key_state_e st
);
  import guard_pkg::*;

  logic in_win, acc_wr, acc_rd, to_key;

  always_comb begin
    in_win = 1'b0;
    for (int w = 0; w < NUM_WIN; w++)
      if (req_addr >= WIN_LO[w*AW +: AW] && req_addr <= WIN_HI[w*AW +: AW]) in_win = 1'b1;
  end

  assign acc_wr = req_valid && req_ready && req_write;
  assign acc_rd = req_valid && req_ready && !req_write;
  assign to_key = req_addr == KEY_ADDR;

  assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && to_key && req_wdata == KEY_SECOND && st == KS_ARMED) |=> st == KS_OPEN);

  assert_zero_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && to_key && req_wdata == '0) |=> st == KS_LOCKED);

  assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KS_ARMED && acc_wr && !(to_key && req_wdata == KEY_SECOND)) |=> st == KS_LOCKED);

  assert_guard_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we && in_win && !to_key) |-> st == KS_OPEN);

  assert_free_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !in_win && !to_key) |-> bank_we);

  assert_open_key_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KS_OPEN && acc_wr && to_key) |=> st == KS_LOCKED);

  assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid);

  assert_read_no_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd || !req_valid) |-> !bank_we);

  assert_read_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_wr) |=> $stable(st));

  assert_key_no_we_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && to_key) |-> !bank_we);

endmodule

bind key_guard key_guard_chk #(
  .AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND),
  .NUM_WIN(NUM_WIN), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .bank_we   (bank_we),
  .rsp_valid (rsp_valid),
  .st        (key_state)
);

// File: tb/test_key_guard.sv
module test_key_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] KADDR = 8'h2E;
  localparam logic [7:0] K1 = 8'hA5;
  localparam logic [7:0] K2 = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0, bank_rdata = '0;
  logic req_ready, bank_we, rsp_valid;
  logic [7:0] bank_addr, bank_wdata, rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state: 0 closed, 1 armed, 2 open
  int mst = 0;
  bit exp_rv = 0;
  logic [7:0] exp_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  key_guard i_key_guard (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .bank_we(bank_we), .bank_addr(bank_addr), .bank_wdata(bank_wdata),
    .bank_rdata(bank_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic bit guarded(input logic [7:0] a);
    return (a >= 8'h20 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h3F);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit v, input bit w,
                      input logic [7:0] a, input logic [7:0] d, input logic [7:0] rd);
    bit exp_we, nrv;
    logic [7:0] nrd;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; bank_rdata = rd;
    #1;
    exp_we = v && w && (a != KADDR) && (!guarded(a) || mst == 2);
    check(tag, "req_ready", int'(req_ready), 1);
    check(tag, "bank_we", int'(bank_we), int'(exp_we));
    if (exp_we) begin
      check("R11", "bank_addr", int'(bank_addr), int'(a));
      check("R11", "bank_wdata", int'(bank_wdata), int'(d));
    end
    check(tag, "rsp_valid", int'(rsp_valid), int'(exp_rv));
    if (exp_rv) check(tag, "rsp_data", int'(rsp_data), int'(exp_rd));
    nrv = v && !w;
    nrd = (a == KADDR) ? {7'b0, mst == 2} : rd;
    if (v && w) begin
      case (mst)
        0: if (a == KADDR && d == K1) mst = 1;
        1: mst = (a == KADDR && d == K2) ? 2 : 0;
        default: if (a == KADDR) mst = 0;
      endcase
    end
    exp_rv = nrv;
    exp_rd = nrd;
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [7:0] d);
    step(tag, 1'b1, 1'b1, a, d, 8'h00);
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] bd);
    step(tag, 1'b1, 1'b0, a, 8'h00, bd);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b1, 8'h31, 8'hFF, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "ready in reset", int'(req_ready), 0);
    check("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    idle("R1");
    rd("R1", KADDR, 8'hEE);          // closed after reset
    wr("R5", 8'h31, 8'h11);          // dropped while closed
    idle("R8");

    // Wrong order: second key alone
    wr("R10", KADDR, K2);
    wr("R10", 8'h22, 8'h44);
    rd("R10", KADDR, 8'h00);

    // Free addresses always pass
    wr("R6", 8'h10, 8'h01);
    wr("R6", 8'h1F, 8'h02);
    wr("R6", 8'h28, 8'h03);
    wr("R6", 8'h2F, 8'h04);
    wr("R6", 8'h40, 8'h05);

    // Proper unlock, then guarded writes at window bounds
    wr("R2", KADDR, K1);
    rd("R2", KADDR, 8'h00);          // armed reads as closed
    wr("R2", KADDR, K1);             // second K1 aborts (R4)
    rd("R4", KADDR, 8'h00);
    wr("R2", KADDR, K1);
    wr("R2", KADDR, K2);
    rd("R2", KADDR, 8'h00);
    wr("R5", 8'h20, 8'hA0);
    wr("R5", 8'h27, 8'hA1);
    wr("R5", 8'h30, 8'hA2);
    wr("R5", 8'h3F, 8'hA3);
    wr("R6", 8'h10, 8'hA4);          // free write keeps guard open
    rd("R9", 8'h35, 8'hC3);
    rd("R9", 8'h35, 8'h3C);          // back-to-back reads
    step("R9", 1'b0, 1'b0, 8'h35, 8'h00, 8'h77);
    rd("R8", KADDR, 8'h00);
    wr("R5", 8'h36, 8'hB6);

    // Key writes while open lock
    wr("R7", KADDR, K1);
    rd("R7", KADDR, 8'h00);
    wr("R7", 8'h33, 8'h01);
    wr("R2", KADDR, K1); wr("R2", KADDR, K2);
    wr("R7", KADDR, K2);
    wr("R7", 8'h24, 8'h02);

    // Armed then intruders
    wr("R4", KADDR, K1); wr("R4", 8'h10, 8'h55); wr("R4", KADDR, K2);
    rd("R4", KADDR, 8'h00);
    wr("R4", 8'h30, 8'h66);
    wr("R4", KADDR, K1); wr("R4", KADDR, 8'h77); wr("R4", 8'h3A, 8'h01);
    wr("R4", KADDR, K1); wr("R4", 8'h31, 8'h01); wr("R4", KADDR, K2);
    rd("R4", KADDR, 8'h00);

    // Zero relocks from open and from armed
    wr("R3", KADDR, K1); wr("R3", KADDR, K2);
    rd("R3", KADDR, 8'h00);
    wr("R3", KADDR, 8'h00);
    rd("R3", KADDR, 8'h00);
    wr("R3", 8'h25, 8'h09);
    wr("R3", KADDR, K1); wr("R3", KADDR, 8'h00); wr("R3", KADDR, K2);
    rd("R3", KADDR, 8'h00);

    // Reads interleaved with unlock do not disturb it
    wr("R8", KADDR, K1);
    wr("R8", KADDR, K2);
    rd("R8", 8'h31, 8'h5E);
    rd("R8", KADDR, 8'h00);
    wr("R8", 8'h31, 8'h42);
    wr("R3", KADDR, 8'h00);
    idle("R8");
    idle("R8");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule